// File: doc/BRIEF.md
# Split-Register Performance Monitor

This block counts clock cycles and selected hardware events for profiling. It holds one cycle counter and a parameterised number of event counters (four by default). Each counter is 32 bits wide. Control, interrupt enables, overflow flags and event selection each have their own register on a simple single-cycle register bus. Writes are registered. Reads are combinational on the current address.

Each event counter has an 8-bit code in the event select register. The code picks one strobe from the `event_i` vector. The counter then adds one in every enabled cycle in which that strobe is high. When a counter wraps, it sets its overflow flag. A single interrupt line reports any flag whose matching enable bit is set. Software clears flags by writing ones to them. The cycle counter can run at the full clock rate or advance once every 64 enabled clocks.

Register word addresses:
- Control register: 0.
- Interrupt enable register: 1.
- Overflow flag register: 2.
- Event select register: 3.
- Cycle counter: 4.
- Event counters 0 to 3: 5 to 8.

Top module: `perf_monitor`

## Requirements
- R1: After reset, every counter reads 0, and the interrupt enable and overflow flag registers read 0. The event select register reads 0xFFFFFFFF, so all event counters start off. `irq_o` is low.
- R2: Control register:
  - Bit 0 is the global enable. Bit 3 selects divided cycle counting. Both are read/write.
  - Reads return the constant `ID_CODE` in bits 31:24.
  - Bits 1, 2 and 23:4 always read 0.
  - Writes to bits 31:24 and 23:4 have no effect.
- R3: Writing 1 to control bit 1 clears every event counter. Writing 1 to control bit 2 clears the cycle counter and its divider. Both act once in the write cycle, read back 0 and leave later writes unaffected.
- R4: While enabled, the cycle counter advances on every clock when bit 3 is 0. When bit 3 is 1, it advances once per 64 enabled clocks.
- R5: The event select register holds four 8-bit codes: counter 0 in bits 7:0, counter 1 in 15:8, counter 2 in 23:16 and counter 3 in 31:24. Code k counts the cycles in which `event_i[k]` is high while enabled. Code 0xFF, or any code of `NUM_EVENTS` or more, counts nothing.
- R6: While the global enable is 0, no counter changes except through a bus write or a reset bit.
- R7: Each counter can be read and written at its own address. A bus write to a counter wins over an increment in the same cycle.
- R8: A counter that increments from 0xFFFFFFFF becomes 0 and sets its overflow flag. Flag bit 0 is the cycle counter and bits 1 to 4 are event counters 0 to 3.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it alone. If an overflow occurs in the same cycle as the clearing write, the flag stays set.
- R10: `irq_o` is high exactly when some flag bit and the interrupt enable bit at the same position are both 1. The enable register uses the same positions as the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| event_i | input | NUM_EVENTS (32) | Per-cycle event strobes |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Assertions check the following on every cycle:
- A bus write to a counter always wins over its increment.
- A wrapping counter lands on zero.
- An idle counter holds its value.
- A set flag persists unless a clearing write hits its bit.
- The interrupt is never raised with all enables off.

The directed scenarios show the remaining behaviour:
- Exact counts, which need a model of event patterns and enable timing.
- The 64-clock divider period.
- Read masking of the control register.
- The race between a clearing write and a fresh overflow.
- The one-shot nature of the reset bits.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int CODE_W   = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd2;
  localparam logic [ADDR_W-1:0] A_EVSEL = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT0  = 4'd4;  // cycle counter, event counters follow

  localparam int B_EN      = 0;
  localparam int B_EVT_CLR = 1;
  localparam int B_CYC_CLR = 2;
  localparam int B_DIV     = 3;

  localparam logic [CODE_W-1:0] CODE_OFF = 8'hFF;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (we_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = inc_i & ~we_i & ~clr_i & (&cnt_q);
  assign cnt_o  = cnt_q;

  // R7: write wins over increment
  p_wr_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i) |=> (cnt_q == $past(wdata_i)));
  // R8: wrap lands on zero
  p_wrap_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  // R6: idle counter holds
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !we_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pm_event_sel.sv
module pm_event_sel #(
  parameter int NUM_EVENTS = 32,
  parameter int CODE_W     = 8
) (
  input  logic [CODE_W-1:0]     code_i,
  input  logic [NUM_EVENTS-1:0] event_i,
  output logic                  hit_o
);
  // codes at or above NUM_EVENTS (incl. the off code) match nothing
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < NUM_EVENTS; k++)
      if (code_i == CODE_W'(k)) hit_o = event_i[k];
  end
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
  import perfmon_pkg::*;
#(
  parameter int          NUM_EVT_CNT   = 4,
  parameter int          NUM_EVENTS    = 32,
  parameter int          PRESCALE_LOG2 = 6,
  parameter logic [7:0]  ID_CODE       = 8'h14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  input  logic [NUM_EVENTS-1:0] event_i,
  output logic                  irq_o
);
  localparam int NUM_CNT = NUM_EVT_CNT + 1;
  localparam int SEL_W   = NUM_EVT_CNT * CODE_W;

  logic                     en_q, div_q;
  logic [NUM_CNT-1:0]       ien_q, flag_q, wrap, inc, cnt_we;
  logic [SEL_W-1:0]         evsel_q;
  logic [PRESCALE_LOG2-1:0] pre_q;
  logic [DATA_W-1:0]        cnt [NUM_CNT];

  wire ctrl_we = bus_we_i && (bus_addr_i == A_CTRL);
  wire evt_clr = ctrl_we && bus_wdata_i[B_EVT_CLR];
  wire cyc_clr = ctrl_we && bus_wdata_i[B_CYC_CLR];
  wire [NUM_CNT-1:0] w1c_mask =
    (bus_we_i && bus_addr_i == A_FLAG) ? bus_wdata_i[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      div_q   <= 1'b0;
      ien_q   <= '0;
      evsel_q <= '1;
    end else if (bus_we_i) begin
      unique case (bus_addr_i)
        A_CTRL:  begin en_q <= bus_wdata_i[B_EN]; div_q <= bus_wdata_i[B_DIV]; end
        A_IEN:   ien_q   <= bus_wdata_i[NUM_CNT-1:0];
        A_EVSEL: evsel_q <= bus_wdata_i[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  // cycle divider
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (cyc_clr)         pre_q <= '0;
    else if (en_q && div_q)   pre_q <= pre_q + 1'b1;
  end
  assign inc[0] = en_q && (!div_q || (&pre_q));

  genvar g;
  generate
    for (g = 0; g < NUM_EVT_CNT; g++) begin : g_sel
      logic hit;
      pm_event_sel #(.NUM_EVENTS(NUM_EVENTS), .CODE_W(CODE_W)) u_sel (
        .code_i (evsel_q[g*CODE_W +: CODE_W]),
        .event_i(event_i),
        .hit_o  (hit)
      );
      assign inc[g+1] = en_q && hit;
    end

    for (g = 0; g < NUM_CNT; g++) begin : g_cnt
      assign cnt_we[g] = bus_we_i && (bus_addr_i == ADDR_W'(A_CNT0 + g));
      pm_counter #(.W(DATA_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  ((g == 0) ? cyc_clr : evt_clr),
        .we_i   (cnt_we[g]),
        .wdata_i(bus_wdata_i),
        .inc_i  (inc[g]),
        .cnt_o  (cnt[g]),
        .wrap_o (wrap[g])
      );
      // R9: flag survives unless its bit is cleared
      p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q[g] && !w1c_mask[g]) |=> flag_q[g]);
    end
  endgenerate

  // new overflow beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~w1c_mask) | wrap;
  end

  assign irq_o = |(flag_q & ien_q);

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[B_EN]  = en_q;
        bus_rdata_o[B_DIV] = div_q;
        bus_rdata_o[31:24] = ID_CODE;
      end
      A_IEN:   bus_rdata_o[NUM_CNT-1:0] = ien_q;
      A_FLAG:  bus_rdata_o[NUM_CNT-1:0] = flag_q;
      A_EVSEL: bus_rdata_o[SEL_W-1:0]   = evsel_q;
      default:
        for (int i = 0; i < NUM_CNT; i++)
          if (bus_addr_i == ADDR_W'(A_CNT0 + i)) bus_rdata_o = cnt[i];
    endcase
  end

  // R10: no interrupt with all enables off
  p_irq_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_q != '0));
endmodule

// File: tb/perf_monitor_tb.sv
module perf_monitor_tb;
  localparam logic [7:0] ID = 8'h14;
  localparam logic [31:0] IDW = {ID, 24'h0};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] ev = '0;
  logic        irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  perf_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .event_i(ev), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_rd(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_rd("R1 ctrl", 4'd0, IDW);
    chk_rd("R1 ien", 4'd1, 32'h0);
    chk_rd("R1 flags", 4'd2, 32'h0);
    chk_rd("R1 evsel", 4'd3, 32'hFFFF_FFFF);
    for (int i = 4; i < 9; i++) chk_rd("R1 counter", 4'(i), 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_ctrl_mask();
    wr(4'd0, 32'hFFFF_FFF9);
    chk_rd("R2 ctrl read mask", 4'd0, IDW | 32'h9);
    wr(4'd0, 32'h0);
    chk_rd("R2 ctrl cleared", 4'd0, IDW);
  endtask

  task automatic t_cycle();
    wr(4'd0, 32'h4);
    wr(4'd0, 32'h1);
    idle(9);
    wr(4'd0, 32'h0);
    chk_rd("R4 full-rate count", 4'd4, 32'd10);
    idle(5);
    chk_rd("R6 held while disabled", 4'd4, 32'd10);
    wr(4'd0, 32'h4);
    wr(4'd0, 32'h9);
    idle(129);
    wr(4'd0, 32'h0);
    chk_rd("R4 divided count", 4'd4, 32'd2);
  endtask

  task automatic t_event();
    int e0 = 0, e2 = 0;
    logic [31:0] p;
    wr(4'd0, 32'h2);
    wr(4'd3, 32'h40_09_FF_05);
    chk_rd("R5 evsel readback", 4'd3, 32'h40_09_FF_05);
    wr(4'd0, 32'h1);
    for (int k = 0; k < 20; k++) begin
      p = (k % 5 == 0) ? 32'hFFFF_FFFF : 32'h0;
      if (k % 2 == 0) p[5] = 1'b1;
      if (k % 3 == 0) p[9] = 1'b1;
      if (p[5]) e0++;
      if (p[9]) e2++;
      ev = p;
      @(negedge clk);
    end
    ev = '0;
    wr(4'd0, 32'h0);
    chk_rd("R5 counter0 code 5", 4'd5, 32'(e0));
    chk_rd("R5 counter1 code FF", 4'd6, 32'h0);
    chk_rd("R5 counter2 code 9", 4'd7, 32'(e2));
    chk_rd("R5 counter3 code 64", 4'd8, 32'h0);
    ev = '1;
    idle(5);
    ev = '0;
    chk_rd("R6 events ignored when off", 4'd5, 32'(e0));
  endtask

  task automatic t_write_prio();
    wr(4'd0, 32'h1);
    wr(4'd4, 32'd100);
    wr(4'd0, 32'h0);
    chk_rd("R7 write beats increment", 4'd4, 32'd101);
    wr(4'd7, 32'h1234);
    chk_rd("R7 counter write", 4'd7, 32'h1234);
  endtask

  task automatic t_overflow();
    wr(4'd2, 32'h1F);
    wr(4'd1, 32'h02);
    wr(4'd5, 32'hFFFF_FFFE);
    wr(4'd3, 32'hFFFF_FF05);
    wr(4'd0, 32'h1);
    ev[5] = 1'b1;
    idle(2);
    ev = '0;
    wr(4'd0, 32'h0);
    chk_rd("R8 wrapped to zero", 4'd5, 32'h0);
    chk_rd("R8 flag bit 1", 4'd2, 32'h02);
    chk("R10 irq with enable", {31'h0, irq}, 32'h1);
    wr(4'd1, 32'h0);
    chk("R10 irq masked", {31'h0, irq}, 32'h0);
    wr(4'd1, 32'h02);
    chk("R10 irq re-enabled", {31'h0, irq}, 32'h1);
    wr(4'd2, 32'h1D);
    chk_rd("R9 write zero keeps flag", 4'd2, 32'h02);
    wr(4'd2, 32'h02);
    chk_rd("R9 write one clears", 4'd2, 32'h0);
    chk("R10 irq after clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_race();
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd0, 32'h1);
    wr(4'd2, 32'h01);
    wr(4'd0, 32'h0);
    chk_rd("R9 overflow wins over clear", 4'd2, 32'h01);
    chk_rd("R8 cycle wrap value", 4'd4, 32'd1);
    wr(4'd2, 32'h01);
    chk_rd("R9 later clear", 4'd2, 32'h0);
  endtask

  task automatic t_reset_bits();
    wr(4'd4, 32'd50);
    wr(4'd6, 32'd77);
    wr(4'd8, 32'd3);
    wr(4'd0, 32'h2);
    chk_rd("R3 event clear c1", 4'd6, 32'h0);
    chk_rd("R3 event clear c3", 4'd8, 32'h0);
    chk_rd("R3 cycle untouched", 4'd4, 32'd50);
    chk_rd("R3 bits read zero", 4'd0, IDW);
    wr(4'd0, 32'h4);
    chk_rd("R3 cycle clear", 4'd4, 32'h0);
    wr(4'd6, 32'd5);
    chk_rd("R3 one-shot", 4'd6, 32'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_mask();
    t_cycle();
    t_event();
    t_write_prio();
    t_overflow();
    t_race();
    t_reset_bits();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule